// File: doc/BRIEF.md
# Three-Level Page Walker with Translation Cache

This block turns a 40-bit virtual address into a 40-bit physical address. It walks a three-level page table that lives in ordinary memory, starting from a root table whose byte address comes from a base input. Pages are 8 KB. The 27-bit virtual page number is cut into three 9-bit indices, and each index selects one 4-byte entry in a 512-entry table. Such a table fills 2 KB, so it always sits inside a single page.

A requester hands over one virtual address at a time on a valid/ready port. Some cycles later a one-cycle response carries either the physical address or a fault together with the level that failed. Table entries are fetched through a read port that has its own valid/ready request and a 32-bit data return.

A small fully associative translation cache keeps entries from all three levels. A hit on the complete page number skips every table read. A hit on a shorter prefix lets the walk start partway down the tree. A flush input empties the cache in one cycle.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_rd_valid are 0, and the cache holds no entries, so the first translation needs three table reads.
- R2: Virtual bits 39:31 index the first-level table, bits 30:22 the second and bits 21:13 the third. Bits 12:0 appear unchanged as bits 12:0 of the physical address.
- R3: Each table read goes to the table base plus four times the index for that level. The first-level base is root_base.
- R4: In a table entry, bit 0 is the valid flag and bits 27:1 are a frame number. Bits 31:28 are ignored. The next table base, or the physical page, is the frame number shifted left by 13.
- R5: With an empty cache, a translation issues exactly three reads in the order first, second, third level, and then responds with the physical address.
- R6: When the full 27-bit page number hits in the cache, the response carries the cached frame and no table read is issued.
- R7: When only the 18-bit prefix hits, exactly one read (third level) is issued. When only the 9-bit prefix hits, exactly two reads (second, then third level) are issued. The deepest hit always wins.
- R8: If an entry read has bit 0 clear, the walk stops with no further reads. The response has rsp_fault = 1 and rsp_level = 1, 2 or 3 for the failing level. On success rsp_level is 0.
- R9: Each valid entry read during a walk is written into the cache together with its level. Slots are filled in round-robin order over CACHE_ENTRIES slots, starting at slot 0. Invalid entries are never cached.
- R10: A flush empties the cache and resets the fill order to slot 0 in one cycle. The next translation walks from the root again.
- R11: While mem_rd_valid is 1 and mem_rd_ready is 0, the request and its address stay unchanged on the next cycle.
- R12: Only one translation is in flight at a time. req_ready is 0 from the cycle after acceptance until the response, and rsp_valid is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Invalidate every cache entry |
| root_base | input | 40 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken on this edge |
| req_vaddr | input | 40 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_level | output | 2 | Failing level 1..3, 0 on success |
| rsp_paddr | output | 40 | Translated physical address |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 40 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry contents |

## Verification
The checks assume that memory returns exactly one data beat per accepted read and never answers when no read was accepted. They also assume that root_base and the tables do not change during a walk, and that flush is raised only while the walker is idle. The bench's memory model answers each accepted read once, after zero to two idle cycles, and stretches some handshakes by holding ready low. It keeps the root fixed and raises flush only between requests. Under these conditions a full-page-number hit can have only one matching slot, so that uniqueness is asserted.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
package pgwalk_pkg;

  typedef enum logic [1:0] {
    WL_IDLE,
    WL_LOOK,
    WL_ISSUE,
    WL_WAIT
  } walk_state_e;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_TOP  = 2'd1;
  localparam logic [1:0] LVL_MID  = 2'd2;
  localparam logic [1:0] LVL_LEAF = 2'd3;

endpackage

// File: rtl/pgwalk_pte.sv
`timescale 1ns/1ps
module pgwalk_pte
  import pgwalk_pkg::*;
#(
  parameter int IDX_W     = 9,
  parameter int PAGE_BITS = 13,
  parameter int FRAME_W   = 27,
  parameter int PTE_W     = 32
) (
  input  logic [FRAME_W+PAGE_BITS-1:0] tbl_base,
  input  logic [1:0]                   lvl,
  input  logic [3*IDX_W-1:0]           vpn,
  input  logic [PTE_W-1:0]             pte,
  output logic [FRAME_W+PAGE_BITS-1:0] ent_addr,
  output logic                         pte_ok,
  output logic [FRAME_W-1:0]           pte_frame
);
  localparam int PA_W  = FRAME_W + PAGE_BITS;
  localparam int VPN_W = 3 * IDX_W;

  logic [IDX_W-1:0] idx;

  // pick the index slice belonging to the current level
  always_comb begin
    case (lvl)
      LVL_TOP: idx = vpn[VPN_W-1 -: IDX_W];
      LVL_MID: idx = vpn[VPN_W-IDX_W-1 -: IDX_W];
      default: idx = vpn[IDX_W-1:0];
    endcase
  end

  // four bytes per entry
  assign ent_addr  = tbl_base + (PA_W'(idx) << 2);
  assign pte_ok    = pte[0];
  assign pte_frame = pte[FRAME_W:1];

  logic unused_pte_hi;
  assign unused_pte_hi = ^pte[PTE_W-1:FRAME_W+1];

endmodule

// File: rtl/pgwalk_tcache.sv
`timescale 1ns/1ps
module pgwalk_tcache
  import pgwalk_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 9,
  parameter int FRAME_W = 27
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic [3*IDX_W-1:0]   look_vpn,
  output logic [1:0]           hit_lvl,
  output logic [FRAME_W-1:0]   hit_frame,
  input  logic                 fill_en,
  input  logic [1:0]           fill_lvl,
  input  logic [3*IDX_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0]   fill_frame
);
  localparam int VPN_W = 3 * IDX_W;
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_vld;
  logic [1:0]         ent_lvl   [ENTRIES];
  logic [VPN_W-1:0]   ent_tag   [ENTRIES];
  logic [FRAME_W-1:0] ent_frame [ENTRIES];
  logic [PTR_W-1:0]   fill_ptr;

  logic [ENTRIES-1:0] m_top, m_mid, m_leaf;
  logic [FRAME_W-1:0] f_top, f_mid, f_leaf;

  // per-slot prefix compare, width of the compare set by the slot's level
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign m_top[e]  = ent_vld[e] && (ent_lvl[e] == LVL_TOP) &&
                       (ent_tag[e][VPN_W-1 -: IDX_W] == look_vpn[VPN_W-1 -: IDX_W]);
    assign m_mid[e]  = ent_vld[e] && (ent_lvl[e] == LVL_MID) &&
                       (ent_tag[e][VPN_W-1 -: 2*IDX_W] == look_vpn[VPN_W-1 -: 2*IDX_W]);
    assign m_leaf[e] = ent_vld[e] && (ent_lvl[e] == LVL_LEAF) &&
                       (ent_tag[e] == look_vpn);
  end

  // deepest match wins
  always_comb begin
    f_top  = '0;
    f_mid  = '0;
    f_leaf = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (m_top[e])  f_top  = ent_frame[e];
      if (m_mid[e])  f_mid  = ent_frame[e];
      if (m_leaf[e]) f_leaf = ent_frame[e];
    end
    if (|m_leaf) begin
      hit_lvl   = LVL_LEAF;
      hit_frame = f_leaf;
    end else if (|m_mid) begin
      hit_lvl   = LVL_MID;
      hit_frame = f_mid;
    end else if (|m_top) begin
      hit_lvl   = LVL_TOP;
      hit_frame = f_top;
    end else begin
      hit_lvl   = LVL_NONE;
      hit_frame = '0;
    end
  end

  // valid bits and replacement pointer; flush beats a same-cycle fill
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ent_vld  <= '0;
      fill_ptr <= '0;
    end else if (fill_en) begin
      ent_vld[fill_ptr] <= 1'b1;
      fill_ptr <= (fill_ptr == PTR_W'(ENTRIES - 1)) ? '0 : fill_ptr + 1'b1;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_lvl[fill_ptr]   <= fill_lvl;
      ent_tag[fill_ptr]   <= fill_vpn;
      ent_frame[fill_ptr] <= fill_frame;
    end
  end

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_vld == '0));

  // R9
  leaf_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_leaf));

  // R9
  fill_occupies_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=> ($countones(ent_vld) >= 1));

endmodule

// File: rtl/pgwalk_top.sv
`timescale 1ns/1ps
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int IDX_W         = 9,
  parameter int PAGE_BITS     = 13,
  parameter int FRAME_W       = 27,
  parameter int PTE_W         = 32,
  parameter int CACHE_ENTRIES = 8,
  localparam int VA_W         = 3 * IDX_W + PAGE_BITS,
  localparam int PA_W         = FRAME_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [PA_W-1:0]   root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_level,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);
  localparam int VPN_W = 3 * IDX_W;

  walk_state_e        state;
  logic [VA_W-1:0]    va_q;
  logic [1:0]         lvl_q;
  logic [PA_W-1:0]    base_q;

  logic [VPN_W-1:0]   vpn;
  logic [1:0]         hit_lvl;
  logic [FRAME_W-1:0] hit_frame;
  logic               pte_ok;
  logic [FRAME_W-1:0] pte_frame;
  logic               walk_fill;

  assign vpn          = va_q[VA_W-1:PAGE_BITS];
  assign req_ready    = (state == WL_IDLE);
  assign mem_rd_valid = (state == WL_ISSUE);
  assign walk_fill    = (state == WL_WAIT) && mem_rsp_valid && pte_ok;

  pgwalk_pte #(
    .IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W), .PTE_W(PTE_W)
  ) u_pte (
    .tbl_base (base_q),
    .lvl      (lvl_q),
    .vpn      (vpn),
    .pte      (mem_rsp_data),
    .ent_addr (mem_rd_addr),
    .pte_ok   (pte_ok),
    .pte_frame(pte_frame)
  );

  pgwalk_tcache #(
    .ENTRIES(CACHE_ENTRIES), .IDX_W(IDX_W), .FRAME_W(FRAME_W)
  ) u_tcache (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .look_vpn  (vpn),
    .hit_lvl   (hit_lvl),
    .hit_frame (hit_frame),
    .fill_en   (walk_fill),
    .fill_lvl  (lvl_q),
    .fill_vpn  (vpn),
    .fill_frame(pte_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WL_IDLE;
      va_q      <= '0;
      lvl_q     <= LVL_NONE;
      base_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_level <= LVL_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        WL_IDLE: begin
          if (req_valid) begin
            va_q  <= req_vaddr;
            state <= WL_LOOK;
          end
        end
        WL_LOOK: begin
          case (hit_lvl)
            LVL_LEAF: begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_level <= LVL_NONE;
              rsp_paddr <= {hit_frame, va_q[PAGE_BITS-1:0]};
              state     <= WL_IDLE;
            end
            LVL_MID: begin
              lvl_q  <= LVL_LEAF;
              base_q <= {hit_frame, {PAGE_BITS{1'b0}}};
              state  <= WL_ISSUE;
            end
            LVL_TOP: begin
              lvl_q  <= LVL_MID;
              base_q <= {hit_frame, {PAGE_BITS{1'b0}}};
              state  <= WL_ISSUE;
            end
            default: begin
              lvl_q  <= LVL_TOP;
              base_q <= root_base;
              state  <= WL_ISSUE;
            end
          endcase
        end
        WL_ISSUE: begin
          if (mem_rd_ready) state <= WL_WAIT;
        end
        WL_WAIT: begin
          if (mem_rsp_valid) begin
            if (!pte_ok) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_level <= lvl_q;
              rsp_paddr <= '0;
              state     <= WL_IDLE;
            end else if (lvl_q == LVL_LEAF) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_level <= LVL_NONE;
              rsp_paddr <= {pte_frame, va_q[PAGE_BITS-1:0]};
              state     <= WL_IDLE;
            end else begin
              base_q <= {pte_frame, {PAGE_BITS{1'b0}}};
              lvl_q  <= lvl_q + 2'd1;
              state  <= WL_ISSUE;
            end
          end
        end
        default: state <= WL_IDLE;
      endcase
    end
  end

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  fault_level_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_level != LVL_NONE));

endmodule

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;
  localparam int ENTRIES = 8;
  localparam logic [39:0] ROOT = 40'h00_0020_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [39:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [1:0]  rsp_level;
  logic [39:0] rsp_paddr, mem_rd_addr;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2 clk = ~clk;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst(rst), .flush(flush), .root_base(ROOT),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_paddr(rsp_paddr), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mem [logic [39:0]];

  // reference cache model
  bit          mv [ENTRIES];
  logic [1:0]  ml [ENTRIES];
  logic [26:0] mt [ENTRIES];
  logic [26:0] mf [ENTRIES];
  int          mptr = 0;

  // scoreboard queues
  bit          exp_fault [$];
  logic [1:0]  exp_lvl   [$];
  logic [39:0] exp_pa    [$];
  int          exp_nrd   [$];
  string       exp_rq    [$];
  logic [39:0] exp_addr  [$];
  logic [39:0] rd_log    [$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [39:0] mkva(input int a, input int b, input int c, input int off);
    logic [31:0] ua, ub, uc, uo;
    ua = a; ub = b; uc = c; uo = off;
    return {ua[8:0], ub[8:0], uc[8:0], uo[12:0]};
  endfunction

  // valid entry with junk in bits 31:28 (R4)
  task automatic setpte(input logic [26:0] tfr, input int idx, input logic [26:0] fr);
    logic [31:0] ui;
    ui = idx;
    mem[{tfr, 13'b0} + {29'd0, ui[8:0], 2'b00}] = {4'hA, fr, 1'b1};
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int e = 0; e < ENTRIES; e++) mv[e] = 1'b0;
    mptr = 0;
  endtask

  // driver: predict from requirements, push expectation, then issue
  task automatic translate(input logic [39:0] va, input string rq);
    logic [26:0] vpn;
    logic [1:0]  lv, flv;
    logic [39:0] base, addr, pa;
    logic [31:0] d;
    logic [8:0]  idx;
    int          nrd;
    bit          done, flt;
    vpn = va[39:13]; lv = 2'd1; base = ROOT; nrd = 0;
    done = 1'b0; flt = 1'b0; flv = 2'd0; pa = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (mv[e] && ml[e] == 2'd3 && mt[e] == vpn) begin done = 1'b1; pa = {mf[e], va[12:0]}; end
    if (!done)
      for (int e = 0; e < ENTRIES; e++)
        if (mv[e] && ml[e] == 2'd2 && mt[e][26:9] == vpn[26:9]) begin lv = 2'd3; base = {mf[e], 13'b0}; end
    if (!done && lv == 2'd1)
      for (int e = 0; e < ENTRIES; e++)
        if (mv[e] && ml[e] == 2'd1 && mt[e][26:18] == vpn[26:18]) begin lv = 2'd2; base = {mf[e], 13'b0}; end
    while (!done) begin
      idx  = (lv == 2'd1) ? vpn[26:18] : (lv == 2'd2) ? vpn[17:9] : vpn[8:0];
      addr = base + {29'd0, idx, 2'b00};
      exp_addr.push_back(addr);
      nrd++;
      d = mem.exists(addr) ? mem[addr] : 32'd0;
      if (!d[0]) begin
        flt = 1'b1; flv = lv; done = 1'b1;
      end else begin
        mv[mptr] = 1'b1; ml[mptr] = lv; mt[mptr] = vpn; mf[mptr] = d[27:1];
        mptr = (mptr + 1) % ENTRIES;
        if (lv == 2'd3) begin pa = {d[27:1], va[12:0]}; done = 1'b1; end
        else begin base = {d[27:1], 13'b0}; lv = lv + 2'd1; end
      end
    end
    exp_fault.push_back(flt);
    exp_lvl.push_back(flv);
    exp_pa.push_back(pa);
    exp_nrd.push_back(nrd);
    exp_rq.push_back(rq);

    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R12: busy right after acceptance
    chk(req_ready == 1'b0, "R12", "req_ready after accept", req_ready, 0);
    while (exp_fault.size() != 0) @(negedge clk);
  endtask

  // memory responder with back-pressure; also checks R11
  initial begin
    int          delay;
    int          rr;
    bit          prev_stall;
    logic [39:0] a, prev_addr;
    delay = -1; rr = 0; prev_stall = 1'b0; a = '0; prev_addr = '0;
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (delay == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(a) ? mem[a] : 32'd0;
      end
      if (delay >= 0) delay--;
      if (prev_stall) begin
        chk(mem_rd_valid == 1'b1, "R11", "request dropped while stalled", mem_rd_valid, 1);
        chk(mem_rd_addr == prev_addr, "R11", "address moved while stalled", mem_rd_addr, prev_addr);
      end
      rr++;
      mem_rd_ready = (rr % 4 != 0);
      prev_stall = mem_rd_valid && !mem_rd_ready;
      prev_addr  = mem_rd_addr;
      if (mem_rd_valid && mem_rd_ready) begin
        a = mem_rd_addr;
        rd_log.push_back(a);
        delay = rr % 3;
      end
    end
  end

  // monitor: pop and compare
  initial begin
    bit          ef;
    logic [1:0]  el;
    logic [39:0] ep, ea;
    int          en;
    string       rq;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_fault.size() == 0) begin
          chk(1'b0, "R12", "unexpected response", rsp_paddr, 0);
        end else begin
          ef = exp_fault.pop_front(); el = exp_lvl.pop_front(); ep = exp_pa.pop_front();
          en = exp_nrd.pop_front();   rq = exp_rq.pop_front();
          chk(rsp_fault == ef, rq, "fault flag", rsp_fault, ef);
          chk(rsp_level == el, rq, "level", rsp_level, el);
          if (!ef) chk(rsp_paddr == ep, rq, "physical address", rsp_paddr, ep);
          chk(rd_log.size() == en, rq, "table read count", rd_log.size(), en);
          for (int k = 0; k < en; k++) begin
            ea = exp_addr.pop_front();
            if (k < rd_log.size()) chk(rd_log[k] == ea, rq, "table read address", rd_log[k], ea);
          end
        end
        rd_log.delete();
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int e = 0; e < ENTRIES; e++) mv[e] = 1'b0;
    setpte(27'h100, 5, 27'h200);
    setpte(27'h200, 7, 27'h300);
    setpte(27'h300, 9, 27'h7ABCDE);
    setpte(27'h300, 10, 27'h123456);
    setpte(27'h200, 8, 27'h310);
    setpte(27'h310, 1, 27'h0ABCD);
    setpte(27'h100, 511, 27'h600);
    setpte(27'h600, 511, 27'h601);
    setpte(27'h601, 511, 27'h7FFFFFF);
    for (int k = 0; k < 4; k++) begin
      setpte(27'h100, 10 + k, 27'h400 + 27'(k));
      setpte(27'h400 + 27'(k), 0, 27'h500 + 27'(k));
      setpte(27'h500 + 27'(k), 0, 27'h1000 + 27'(k));
    end
    // invalid leaf entry with frame bits set (R4/R8)
    mem[{27'h300, 13'b0} + 40'd44] = 32'hFFFF_FFFE;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid after reset", mem_rd_valid, 0);

    translate(mkva(5, 7, 9, 'h123),       "R1/R2/R3/R4/R5 cold walk");
    translate(mkva(5, 7, 9, 'h1FFF),      "R6/R2 leaf hit");
    translate(mkva(5, 7, 10, 0),          "R7 mid-prefix hit");
    translate(mkva(5, 8, 1, 'h7),         "R7 top-prefix hit");
    translate(mkva(511, 511, 511, 'h1FFF), "R2/R4 all-ones address");
    translate(mkva(6, 0, 0, 0),           "R8 first-level fault");
    translate(mkva(5, 9, 0, 0),           "R8 second-level fault");
    translate(mkva(5, 7, 11, 0),          "R8 third-level fault");
    translate(mkva(5, 7, 11, 0),          "R8/R9 fault not cached");
    for (int k = 0; k < 4; k++) translate(mkva(10 + k, 0, 0, k), "R9 round-robin fill");
    translate(mkva(5, 7, 9, 'h40),        "R9 after eviction");
    translate(mkva(5, 7, 9, 'h41),        "R9 refilled hit");
    do_flush();
    translate(mkva(5, 7, 9, 0),           "R10 walk after flush");
    translate(mkva(5, 7, 10, 'h5),        "R10 refill order");

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule